// File: doc/BRIEF.md
# Match/capture timer with PWM

A 32-bit counter/timer peripheral controlled through a flat word-addressed register bus. The counter advances through a programmable prescaler. By default the prescaler is fed by the block clock. In external count mode it is fed instead by synchronized edges on one chosen capture input. Four compare channels watch the counter. Each can flag an interrupt, restart the counter, or halt it. Each also drives one match output pin through a two-bit action: keep, drive low, drive high, or toggle.

Two capture inputs pass through a synchronizer. On a chosen edge (rising, falling or both) each one copies the counter into its own capture register and can flag an interrupt. In PWM mode, the first three compare channels become single-edge PWM outputs. The last compare channel, with its restart bit set, fixes the cycle length. All flags share one interrupt line.

Registers (word index): 0 control, 1 count mode, 2 prescale limit, 3 prescale count (read only), 4 counter, 5 interrupt flags, 6 channel control, 7 match output control, 8 capture control, 9 PWM enables, 10..13 compare values 0..3, 14..15 capture values 0..1 (read only).

Top module: `mtimer_pwm`

## Requirements
- R1: After reset every register reads 0, `match_out` is 0 and `irq` is 0.
- R2: Control bit 0 is run and bit 1 is clear. While clear is 1, the counter and prescale count are held at 0. While run is 0, the counter holds. With prescale limit P, the counter advances once per P+1 counted clock cycles.
- R3: A match event occurs on a count step taken while the counter equals a compare value. On that event, the output level of the channel changes according to its 2-bit action in register 7 at bits 4+2i: 00 keep, 01 low, 10 high, 11 toggle. The current levels read back at bits 3:0 and are loaded by a write to them.
- R4: Register 6 gives each channel i three bits: 3i interrupt, 3i+1 restart, 3i+2 halt. On a match of a channel whose restart bit is set, the counter goes to 0 instead of advancing.
- R5: On a match of a channel whose halt bit is set, the run bit is cleared and the counter keeps the compare value.
- R6: Register 5 holds bits 3:0 for the match channels (set when the interrupt bit is on) and bits 5:4 for the capture channels. Writing 1 clears a bit. A set and a clear in the same cycle leave the bit set. `irq` is high while any bit is set.
- R7: Register 8 gives capture channel j bits 3j (rising), 3j+1 (falling) and 3j+2 (interrupt). A selected edge on the synchronized input loads the counter value into capture register j. An edge that is not selected leaves the capture register unchanged.
- R8: In count mode register 1, bit 0 selects external counting, bit 1 counts rising edges, bit 2 counts falling edges, and bit 3 picks capture input 0 or 1. The synchronized edges then replace the clock as the prescaler input.
- R9: Register 9 bit i (i<3) puts channel i in PWM mode. The output is then 1 while counter >= compare value and 0 otherwise. A compare value of 0 gives a constant 1, and a value above the period gives a constant 0.
- R10: With the restart bit of channel 3 set, the counter cycles through 0..compare value 3, so the PWM period is that value + 1 steps.
- R11: Compare values, prescale limit and counter are written and read back through the bus. Reads are combinational on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| cap_in | input | NUM_CAP | Asynchronous capture / count inputs |
| match_out | output | NUM_MATCH | Match / PWM output pins |
| irq | output | 1 | OR of all interrupt flags |

## Verification
A hardware event can set an interrupt flag in the same edge in which software writes 1 to clear it. The bench provokes this by changing a capture input exactly three edges before a flag-clear write. That places the synchronized capture on the same edge as the write. The check passes only if the flag reads back as still set, and the following clear-only write must then leave it at 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BUS_W       = 32;
   localparam int REG_CTRL    = 0;
   localparam int REG_MODE    = 1;
   localparam int REG_PRESC   = 2;
   localparam int REG_PCNT    = 3;
   localparam int REG_TCNT    = 4;
   localparam int REG_ISR     = 5;
   localparam int REG_MCTL    = 6;
   localparam int REG_EXTM    = 7;
   localparam int REG_CCTL    = 8;
   localparam int REG_PWMC    = 9;
   localparam int REG_MR_BASE = 10;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } ext_act_e;

   function automatic logic act_apply(input logic cur, input logic [1:0] act);
      unique case (ext_act_e'(act))
         ACT_LOW:    return 1'b0;
         ACT_HIGH:   return 1'b1;
         ACT_TOGGLE: return ~cur;
         default:    return cur;
      endcase
   endfunction
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_err_stages
      $error("tmr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic [W-1:0] pc,
   output logic         step
);
   logic [W-1:0] pc_q;

   assign step = tick & (pc_q >= limit);
   assign pc   = pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pc_q <= '0;
      else if (clr)   pc_q <= '0;
      else if (tick)  pc_q <= step ? '0 : pc_q + W'(1);
   end
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
   import tmr_pkg::*;
#(
   parameter int CW = 32,
   parameter int NM = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   step,
   input  logic [CW-1:0]          tc,
   input  logic [NM-1:0][CW-1:0]  mr,
   input  logic [2*NM-1:0]        act,
   input  logic                   lvl_wr,
   input  logic [NM-1:0]          lvl_wdata,
   output logic [NM-1:0]          hit,
   output logic [NM-1:0]          lvl
);
   logic [NM-1:0] lvl_q;

   for (genvar i = 0; i < NM; i++) begin : g_cmp
      assign hit[i] = step && (tc == mr[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (lvl_wr) begin
         lvl_q <= lvl_wdata;
      end else begin
         for (int i = 0; i < NM; i++)
            if (hit[i]) lvl_q[i] <= act_apply(lvl_q[i], act[2*i +: 2]);
      end
   end

   assign lvl = lvl_q;
endmodule

// File: rtl/mtimer_pwm.sv
module mtimer_pwm
   import tmr_pkg::*;
#(
   parameter int CW          = 32,
   parameter int NUM_MATCH   = 4,
   parameter int NUM_CAP     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [NUM_CAP-1:0]   cap_in,
   output logic [NUM_MATCH-1:0] match_out,
   output logic                 irq
);
   localparam int NM   = NUM_MATCH;
   localparam int NC   = NUM_CAP;
   localparam int SELW = (NC > 1) ? $clog2(NC) : 1;
   localparam int NREG = REG_MR_BASE + NM + NC;

   if (CW < 2 || CW > BUS_W) begin : g_err_cw
      $error("mtimer_pwm: CW out of range");
   end
   if (NM < 2 || 3*NM > BUS_W) begin : g_err_nm
      $error("mtimer_pwm: NUM_MATCH out of range");
   end
   if (NC < 1 || 3*NC > BUS_W || NM + NC > BUS_W || 3 + SELW > BUS_W) begin : g_err_nc
      $error("mtimer_pwm: NUM_CAP out of range");
   end
   if (NREG > (1 << ADDR_W)) begin : g_err_aw
      $error("mtimer_pwm: ADDR_W too small for register count");
   end

   logic wr_ctrl, wr_mode, wr_presc, wr_tc, wr_isr, wr_mctl, wr_extm, wr_cctl, wr_pwmc;
   assign wr_ctrl  = bus_wr && bus_addr == ADDR_W'(REG_CTRL);
   assign wr_mode  = bus_wr && bus_addr == ADDR_W'(REG_MODE);
   assign wr_presc = bus_wr && bus_addr == ADDR_W'(REG_PRESC);
   assign wr_tc    = bus_wr && bus_addr == ADDR_W'(REG_TCNT);
   assign wr_isr   = bus_wr && bus_addr == ADDR_W'(REG_ISR);
   assign wr_mctl  = bus_wr && bus_addr == ADDR_W'(REG_MCTL);
   assign wr_extm  = bus_wr && bus_addr == ADDR_W'(REG_EXTM);
   assign wr_cctl  = bus_wr && bus_addr == ADDR_W'(REG_CCTL);
   assign wr_pwmc  = bus_wr && bus_addr == ADDR_W'(REG_PWMC);

   logic                  run_q, clr_q;
   logic                  mode_ext_q, mode_rise_q, mode_fall_q;
   logic [SELW-1:0]       mode_sel_q;
   logic [CW-1:0]         presc_q, tc_q, pc;
   logic [NM+NC-1:0]      isr_q;
   logic [3*NM-1:0]       mctl_q;
   logic [2*NM-1:0]       act_q;
   logic [3*NC-1:0]       cctl_q;
   logic [NM-2:0]         pwmc_q;
   logic [NM-1:0][CW-1:0] mr_q;
   logic [NC-1:0][CW-1:0] cr_q;

   logic [NM-1:0] mctl_irq, mctl_rst, mctl_stop, hit, lvl;
   for (genvar i = 0; i < NM; i++) begin : g_mctl
      assign mctl_irq[i]  = mctl_q[3*i];
      assign mctl_rst[i]  = mctl_q[3*i+1];
      assign mctl_stop[i] = mctl_q[3*i+2];
   end

   // capture front end
   logic [NC-1:0] cap_rise, cap_fall, cap_hit, cap_irq;
   for (genvar j = 0; j < NC; j++) begin : g_cap
      tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .din(cap_in[j]),
         .rise(cap_rise[j]), .fall(cap_fall[j]));
      assign cap_hit[j] = (cap_rise[j] & cctl_q[3*j]) | (cap_fall[j] & cctl_q[3*j+1]);
      assign cap_irq[j] = cctl_q[3*j+2];
   end

   // count source
   logic cnt_edge, tick, step, do_rst, do_stop;
   assign cnt_edge = (mode_rise_q & cap_rise[mode_sel_q]) | (mode_fall_q & cap_fall[mode_sel_q]);
   assign tick     = run_q & ~clr_q & (mode_ext_q ? cnt_edge : 1'b1);

   tmr_prescaler #(.W(CW)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(clr_q), .tick(tick),
      .limit(presc_q), .pc(pc), .step(step));

   tmr_match_bank #(.CW(CW), .NM(NM)) u_match (
      .clk(clk), .rst_n(rst_n), .step(step), .tc(tc_q), .mr(mr_q),
      .act(act_q), .lvl_wr(wr_extm), .lvl_wdata(bus_wdata[NM-1:0]),
      .hit(hit), .lvl(lvl));

   assign do_rst  = |(hit & mctl_rst);
   assign do_stop = |(hit & mctl_stop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;  clr_q <= 1'b0;
         mode_ext_q <= 1'b0; mode_rise_q <= 1'b0; mode_fall_q <= 1'b0; mode_sel_q <= '0;
         presc_q <= '0;  tc_q <= '0;  isr_q <= '0;  mctl_q <= '0;
         act_q <= '0;    cctl_q <= '0; pwmc_q <= '0; mr_q <= '0; cr_q <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q <= bus_wdata[0];
            clr_q <= bus_wdata[1];
         end else if (do_stop) begin
            run_q <= 1'b0;
         end
         if (wr_mode) begin
            mode_ext_q  <= bus_wdata[0];
            mode_rise_q <= bus_wdata[1];
            mode_fall_q <= bus_wdata[2];
            mode_sel_q  <= bus_wdata[3 +: SELW];
         end
         if (wr_presc) presc_q <= bus_wdata[CW-1:0];
         if (clr_q)        tc_q <= '0;
         else if (wr_tc)   tc_q <= bus_wdata[CW-1:0];
         else if (do_rst)  tc_q <= '0;
         else if (step && !do_stop) tc_q <= tc_q + CW'(1);
         isr_q <= (isr_q & ~(wr_isr ? bus_wdata[NM+NC-1:0] : '0))
                | {cap_hit & cap_irq, hit & mctl_irq};
         if (wr_mctl) mctl_q <= bus_wdata[3*NM-1:0];
         if (wr_extm) act_q  <= bus_wdata[NM +: 2*NM];
         if (wr_cctl) cctl_q <= bus_wdata[3*NC-1:0];
         if (wr_pwmc) pwmc_q <= bus_wdata[NM-2:0];
         for (int i = 0; i < NM; i++)
            if (bus_wr && bus_addr == ADDR_W'(REG_MR_BASE + i)) mr_q[i] <= bus_wdata[CW-1:0];
         for (int j = 0; j < NC; j++)
            if (cap_hit[j]) cr_q[j] <= tc_q;
      end
   end

   // outputs: PWM channels are all but the last (period) channel
   for (genvar i = 0; i < NM - 1; i++) begin : g_pwm
      assign match_out[i] = pwmc_q[i] ? (tc_q >= mr_q[i]) : lvl[i];
   end
   assign match_out[NM-1] = lvl[NM-1];
   assign irq = |isr_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_CTRL):  bus_rdata = BUS_W'({clr_q, run_q});
         ADDR_W'(REG_MODE):  bus_rdata = BUS_W'({mode_sel_q, mode_fall_q, mode_rise_q, mode_ext_q});
         ADDR_W'(REG_PRESC): bus_rdata = BUS_W'(presc_q);
         ADDR_W'(REG_PCNT):  bus_rdata = BUS_W'(pc);
         ADDR_W'(REG_TCNT):  bus_rdata = BUS_W'(tc_q);
         ADDR_W'(REG_ISR):   bus_rdata = BUS_W'(isr_q);
         ADDR_W'(REG_MCTL):  bus_rdata = BUS_W'(mctl_q);
         ADDR_W'(REG_EXTM):  bus_rdata = BUS_W'({act_q, lvl});
         ADDR_W'(REG_CCTL):  bus_rdata = BUS_W'(cctl_q);
         ADDR_W'(REG_PWMC):  bus_rdata = BUS_W'(pwmc_q);
         default: begin
            for (int i = 0; i < NM; i++)
               if (bus_addr == ADDR_W'(REG_MR_BASE + i)) bus_rdata = BUS_W'(mr_q[i]);
            for (int j = 0; j < NC; j++)
               if (bus_addr == ADDR_W'(REG_MR_BASE + NM + j)) bus_rdata = BUS_W'(cr_q[j]);
         end
      endcase
   end
endmodule

// File: rtl/mtimer_pwm_chk.sv
module mtimer_pwm_chk
   import tmr_pkg::*;
#(
   parameter int CW = 32,
   parameter int NM = 4,
   parameter int NC = 2,
   parameter int AW = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [AW-1:0]    bus_addr,
   input logic             run_q,
   input logic             clr_q,
   input logic [CW-1:0]    tc_q,
   input logic             step,
   input logic [NM+NC-1:0] isr_q,
   input logic [NM-1:0]    hit,
   input logic [NM-1:0]    rst_bits,
   input logic [NM-1:0]    stop_bits
);
   logic wr_tc, wr_isr, wr_ctrl, rst_hit, stop_hit;
   assign wr_tc    = bus_wr && bus_addr == AW'(REG_TCNT);
   assign wr_isr   = bus_wr && bus_addr == AW'(REG_ISR);
   assign wr_ctrl  = bus_wr && bus_addr == AW'(REG_CTRL);
   assign rst_hit  = |(hit & rst_bits);
   assign stop_hit = |(hit & stop_bits);

   p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |=> tc_q == '0);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !clr_q && !wr_tc) |=> tc_q == $past(tc_q));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr_q && !wr_tc && !rst_hit && !stop_hit) |=> tc_q == $past(tc_q) + CW'(1));

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_hit && !clr_q && !wr_tc) |=> tc_q == '0);

   p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_hit && !wr_ctrl) |=> !run_q);

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_isr |=> (isr_q & $past(isr_q)) == $past(isr_q));
endmodule

bind mtimer_pwm mtimer_pwm_chk #(.CW(CW), .NM(NUM_MATCH), .NC(NUM_CAP), .AW(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .run_q(run_q), .clr_q(clr_q), .tc_q(tc_q), .step(step), .isr_q(isr_q),
   .hit(hit), .rst_bits(mctl_rst), .stop_bits(mctl_stop));

// File: tb/mtimer_pwm_tb_top.sv
`timescale 1ns/1ps
module mtimer_pwm_tb_top;
   import tmr_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  cap_in = '0;
   logic [3:0]  match_out;
   logic        irq;

   always #2 clk = ~clk;

   mtimer_pwm dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
      .match_out(match_out), .irq(irq));

   // scoreboard
   logic [31:0] exp_q[$];
   logic [31:0] act_q[$];
   string       tag_q[$];
   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;
   event got_ev;

   function automatic void drain();
      while (act_q.size() > 0 && exp_q.size() > 0) begin
         logic [31:0] a, e;
         string t;
         a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
         n_vec++;
         if (a !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, a, e);
         end
      end
   endfunction

   initial forever begin
      @(got_ev);
      drain();
   end

   task automatic push_exp(input string t, input logic [31:0] e);
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic push_act(input logic [31:0] a);
      act_q.push_back(a);
      -> got_ev;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic chk_rd(input int a, input logic [31:0] e, input string t);
      push_exp(t, e);
      @(negedge clk);
      bus_addr = 4'(a);
      #1 push_act(bus_rdata);
   endtask

   task automatic chk_val(input logic [31:0] a, input logic [31:0] e, input string t);
      push_exp(t, e);
      push_act(a);
   endtask

   task automatic summary();
      drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int c0, c1, c2;
      logic [31:0] tmax;
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk_rd(REG_CTRL, 0, "R1 ctrl after reset");
      chk_rd(REG_TCNT, 0, "R1 counter after reset");
      chk_rd(REG_ISR,  0, "R1 flags after reset");
      chk_rd(REG_EXTM, 0, "R1 match control after reset");
      chk_val(32'(match_out), 0, "R1 match_out after reset");
      chk_val(32'(irq), 0, "R1 irq after reset");

      // R11 register access
      wr(REG_MR_BASE + 1, 32'hDEADBEEF);
      chk_rd(REG_MR_BASE + 1, 32'hDEADBEEF, "R11 compare readback");
      wr(REG_MR_BASE + 1, 0);

      // R2 prescaler: limit 2, 12 counted edges -> counter 4
      wr(REG_PRESC, 2);
      wr(REG_CTRL, 1);
      repeat (11) @(posedge clk);
      wr(REG_CTRL, 0);
      chk_rd(REG_TCNT, 4, "R2 prescaled count");
      chk_rd(REG_PCNT, 0, "R2 prescale wrap");
      chk_rd(REG_PRESC, 2, "R11 prescale readback");
      repeat (4) @(posedge clk);
      chk_rd(REG_TCNT, 4, "R2 hold while stopped");

      // R2 clear holds counter at zero even while running
      wr(REG_TCNT, 7);
      chk_rd(REG_TCNT, 7, "R11 counter write");
      wr(REG_CTRL, 3);
      repeat (5) @(posedge clk);
      chk_rd(REG_TCNT, 0, "R2 clear holds zero");
      wr(REG_CTRL, 0);
      wr(REG_PRESC, 0);

      // R3/R4/R6 toggle + restart + flag on channel 0, compare 5, 8 counted edges
      wr(REG_MR_BASE + 0, 5);
      wr(REG_MCTL, 32'h3);
      wr(REG_EXTM, 32'h30);
      wr(REG_TCNT, 0);
      wr(REG_CTRL, 1);
      repeat (7) @(posedge clk);
      wr(REG_CTRL, 0);
      chk_rd(REG_TCNT, 2, "R4 restart on match");
      chk_val(32'(match_out), 32'h1, "R3 toggle action");
      chk_rd(REG_ISR, 32'h1, "R6 match flag");
      chk_val(32'(irq), 1, "R6 irq high");
      wr(REG_ISR, 32'h1);
      chk_rd(REG_ISR, 0, "R6 write one clears");
      chk_val(32'(irq), 0, "R6 irq low");

      // R3 keep / high / low actions
      wr(REG_MCTL, 0);
      wr(REG_MR_BASE + 1, 3);
      wr(REG_MR_BASE + 2, 3);
      wr(REG_EXTM, 32'h185);
      wr(REG_TCNT, 0);
      wr(REG_CTRL, 1);
      repeat (5) @(posedge clk);
      wr(REG_CTRL, 0);
      chk_rd(REG_TCNT, 6, "R2 unscaled count");
      chk_val(32'(match_out), 32'h3, "R3 keep/high/low actions");
      chk_rd(REG_ISR, 0, "R6 no flag without interrupt bit");

      // R5 halt on channel 2 at compare 4
      wr(REG_EXTM, 0);
      wr(REG_MR_BASE + 2, 4);
      wr(REG_MCTL, 32'h100);
      wr(REG_TCNT, 0);
      wr(REG_CTRL, 1);
      repeat (10) @(posedge clk);
      chk_rd(REG_CTRL, 0, "R5 run cleared by halt");
      chk_rd(REG_TCNT, 4, "R5 counter keeps compare value");
      wr(REG_MCTL, 0);

      // R7 capture
      wr(REG_ISR, 32'h3F);
      wr(REG_TCNT, 100);
      wr(REG_CCTL, 32'h15);
      @(negedge clk) cap_in[1] = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk) cap_in[0] = 1'b1;
      repeat (5) @(posedge clk);
      chk_rd(REG_MR_BASE + 4, 100, "R7 capture on rising edge");
      chk_rd(REG_MR_BASE + 5, 0, "R7 unselected rising edge ignored");
      chk_rd(REG_ISR, 32'h10, "R6 capture flag");
      wr(REG_TCNT, 200);
      @(negedge clk) cap_in[1] = 1'b0;
      repeat (5) @(posedge clk);
      chk_rd(REG_MR_BASE + 5, 200, "R7 capture on falling edge");
      chk_rd(REG_ISR, 32'h10, "R6 no flag without capture interrupt bit");
      wr(REG_TCNT, 300);
      @(negedge clk) cap_in[0] = 1'b0;
      repeat (5) @(posedge clk);
      chk_rd(REG_MR_BASE + 4, 100, "R7 unselected falling edge ignored");

      // R6 set and clear on the same edge: set wins
      @(negedge clk) cap_in[0] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      wr(REG_ISR, 32'h10);
      chk_rd(REG_ISR, 32'h10, "R6 set beats clear");
      chk_rd(REG_MR_BASE + 4, 300, "R7 capture during clear");
      wr(REG_ISR, 32'h10);
      chk_rd(REG_ISR, 0, "R6 clear after collision");
      wr(REG_CCTL, 0);

      // R8 external counting on input 1, both edges
      wr(REG_MODE, 32'hF);
      wr(REG_TCNT, 0);
      wr(REG_CTRL, 1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk) begin cap_in[1] = ~cap_in[1]; cap_in[0] = ~cap_in[0]; end
         repeat (4) @(posedge clk);
      end
      repeat (6) @(posedge clk);
      wr(REG_CTRL, 0);
      chk_rd(REG_TCNT, 4, "R8 counts selected input edges");
      wr(REG_PRESC, 1);
      wr(REG_TCNT, 0);
      wr(REG_CTRL, 1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk) cap_in[1] = ~cap_in[1];
         repeat (4) @(posedge clk);
      end
      repeat (6) @(posedge clk);
      wr(REG_CTRL, 0);
      chk_rd(REG_TCNT, 2, "R8 external edges through prescaler");
      wr(REG_MODE, 0);
      wr(REG_PRESC, 0);

      // R9/R10 PWM
      wr(REG_MR_BASE + 0, 0);
      wr(REG_MR_BASE + 1, 4);
      wr(REG_MR_BASE + 2, 20);
      wr(REG_MR_BASE + 3, 9);
      wr(REG_MCTL, 32'h400);
      wr(REG_EXTM, 0);
      wr(REG_PWMC, 32'h7);
      wr(REG_TCNT, 0);
      wr(REG_CTRL, 1);
      c0 = 0; c1 = 0; c2 = 0; tmax = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         bus_addr = 4'(REG_TCNT);
         #1;
         c0 += int'(match_out[0]);
         c1 += int'(match_out[1]);
         c2 += int'(match_out[2]);
         if (bus_rdata > tmax) tmax = bus_rdata;
      end
      wr(REG_CTRL, 0);
      chk_val(32'(c0), 30, "R9 compare zero constant high");
      chk_val(32'(c1), 18, "R9 duty 6 of 10");
      chk_val(32'(c2), 0, "R9 compare above period constant low");
      chk_val(tmax, 9, "R10 period limit");
      chk_val(32'(match_out[3]), 0, "R10 period channel output unchanged");

      repeat (2) @(posedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule